// File: doc/BRIEF.md
# CIC Decimation Filter

This block is a multistage cascaded integrator-comb decimator. It takes a stream of signed samples at a high rate and produces a low-pass filtered stream at 1/RATE of the accepted input rate. It uses nothing but adders and subtractors. A chain of STAGES integrators runs on every accepted input sample. A counter picks one sample out of every RATE. A chain of STAGES comb sections, each with a differential delay of DIFF_DLY decimated samples, runs on those picked samples.

All integrator and comb registers share one width: the input width plus the bit growth of the DC gain (RATE*DIFF_DLY)^STAGES. The integrators wrap in two's complement and never saturate. Because the comb differences are formed modulo the same width, the wrap cancels and the final result is still exact.

The result is given either at full precision or normalised. In normalised form it is shifted right by the bit growth and trimmed back to the input width, which gives unity DC gain when RATE*DIFF_DLY is a power of two. Typical use is after a digital mixer in a down-conversion chain, where the sample rate is far above the signal bandwidth.

Top module: `cic_decim`

## Requirements
- R1: The internal width is ACC_W = IN_W + ceil(log2((RATE*DIFF_DLY)^STAGES)), and the default build has five stages. With NORMALIZE=0, out_data is ACC_W bits wide, and a constant input c held from reset settles to exactly c*(RATE*DIFF_DLY)^STAGES.
- R2: With NORMALIZE=1, out_data is IN_W bits wide and equals the full-precision result arithmetically shifted right by the bit growth. When RATE*DIFF_DLY is a power of two, a constant input held from reset settles to that same constant.
- R3: Integrators wrap in two's complement without saturation. Constant inputs at the extremes of the input range (largest positive and most negative) still settle to the exact expected value long after the integrators have overflowed.
- R4: out_valid is a one-cycle pulse. It is high in the cycle after the clock edge that accepts every RATE-th sample with in_valid high. Cycles with in_valid low are not counted, and their in_data has no effect on any later output.
- R5: out_data changes only in cycles where out_valid is high, and holds its value in all other cycles.
- R6: While rst is high, out_valid is 0 and out_data is 0.
- R7: The first STAGES output strobes after reset carry the value 0, whatever the input.
- R8: A constant input applied from reset gives its steady-state value on every output strobe from strobe number STAGES*(DIFF_DLY+2)+1 on, counting the first strobe as number 1.
- R9: A synchronous reset in the middle of a stream clears the decimation count. The next strobe follows the RATE-th valid sample accepted after reset is released.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst | input | 1 | Synchronous active-high reset of the whole datapath |
| in_valid | input | 1 | High when in_data carries a sample to accept |
| in_data | input | IN_W | Signed input sample |
| out_valid | output | 1 | One-cycle pulse marking a decimated output |
| out_data | output | OUT_W | Signed result: IN_W bits if NORMALIZE, else ACC_W bits |

## Verification
The bench builds two copies of the filter side by side, both with five stages and a 12-bit input. One copy is normalised, with RATE=8 and DIFF_DLY=1. The other gives full precision, with RATE=4 and DIFF_DLY=2, so the delay lines deeper than one and the unshifted 27-bit result are both exercised with the same 15 bits of growth. Extreme constants drive the integrators far past their wrap point within a few hundred samples. Irregular valid gaps and a mid-stream reset exercise the decimation count in each copy at its own rate.

// File: rtl/cic_pkg.sv
package cic_pkg;
  // Bits needed for a DC gain of (rate*ddly)^stages.
  function automatic int growth_bits(input int stages, input int rate, input int ddly);
    longint prod;
    prod = 1;
    for (int i = 0; i < stages; i++) prod = prod * longint'(rate * ddly);
    return $clog2(prod);
  endfunction
endpackage

// File: rtl/cic_integ_chain.sv
module cic_integ_chain #(
  parameter int W = 27,
  parameter int N = 5
) (
  input  logic                clk,
  input  logic                rst,
  input  logic                en,
  input  logic signed [W-1:0] din,
  output logic signed [W-1:0] dout
);
  logic signed [W-1:0] acc [N];

  // Each stage adds the previous stage's register; wrap is intended.
  for (genvar k = 0; k < N; k++) begin : g_stage
    logic signed [W-1:0] feed;
    if (k == 0) begin : g_first
      assign feed = din;
    end else begin : g_next
      assign feed = acc[k-1];
    end
    always_ff @(posedge clk) begin
      if (rst) acc[k] <= '0;
      else if (en) acc[k] <= acc[k] + feed;
    end
  end

  assign dout = acc[N-1];
endmodule

// File: rtl/cic_rate_ctr.sv
module cic_rate_ctr #(
  parameter int RATE = 8
) (
  input  logic clk,
  input  logic rst,
  input  logic en,
  output logic fire
);
  localparam int CW = (RATE > 1) ? $clog2(RATE) : 1;

  if (RATE == 1) begin : g_unit
    assign fire = en;
  end else begin : g_count
    logic [CW-1:0] cnt;
    logic          at_end;
    assign at_end = (cnt == CW'(RATE - 1));
    assign fire   = en && at_end;
    always_ff @(posedge clk) begin
      if (rst) cnt <= '0;
      else if (en) cnt <= at_end ? '0 : cnt + 1'b1;
    end
  end
endmodule

// File: rtl/cic_comb_chain.sv
module cic_comb_chain #(
  parameter int W   = 27,
  parameter int N   = 5,
  parameter int DLY = 1
) (
  input  logic                clk,
  input  logic                rst,
  input  logic                en,
  input  logic signed [W-1:0] din,
  output logic signed [W-1:0] dout
);
  logic signed [W-1:0] diff_q [N];

  for (genvar k = 0; k < N; k++) begin : g_stage
    logic signed [W-1:0] u;
    logic signed [W-1:0] hist [DLY];
    if (k == 0) begin : g_first
      assign u = din;
    end else begin : g_next
      assign u = diff_q[k-1];
    end
    always_ff @(posedge clk) begin
      if (rst) begin
        diff_q[k] <= '0;
        for (int j = 0; j < DLY; j++) hist[j] <= '0;
      end else if (en) begin
        // Difference against the input seen DLY strobes ago.
        diff_q[k] <= u - hist[DLY-1];
        hist[0]   <= u;
        for (int j = 1; j < DLY; j++) hist[j] <= hist[j-1];
      end
    end
  end

  assign dout = diff_q[N-1];
endmodule

// File: rtl/cic_decim.sv
module cic_decim #(
  parameter int IN_W      = 12,
  parameter int STAGES    = 5,
  parameter int RATE      = 8,
  parameter int DIFF_DLY  = 1,
  parameter bit NORMALIZE = 1'b1,
  localparam int GROWTH   = cic_pkg::growth_bits(STAGES, RATE, DIFF_DLY),
  localparam int ACC_W    = IN_W + GROWTH,
  localparam int OUT_W    = NORMALIZE ? IN_W : ACC_W
) (
  input  logic                    clk,
  input  logic                    rst,
  input  logic                    in_valid,
  input  logic signed [IN_W-1:0]  in_data,
  output logic                    out_valid,
  output logic signed [OUT_W-1:0] out_data
);
  logic signed [ACC_W-1:0] din_ext;
  logic signed [ACC_W-1:0] integ_out;
  logic signed [ACC_W-1:0] comb_out;
  logic signed [OUT_W-1:0] result;
  logic                    fire;

  assign din_ext = {{(ACC_W-IN_W){in_data[IN_W-1]}}, in_data};

  cic_integ_chain #(.W(ACC_W), .N(STAGES)) u_integ (
    .clk(clk), .rst(rst), .en(in_valid), .din(din_ext), .dout(integ_out)
  );

  cic_rate_ctr #(.RATE(RATE)) u_ctr (
    .clk(clk), .rst(rst), .en(in_valid), .fire(fire)
  );

  cic_comb_chain #(.W(ACC_W), .N(STAGES), .DLY(DIFF_DLY)) u_comb (
    .clk(clk), .rst(rst), .en(fire), .din(integ_out), .dout(comb_out)
  );

  if (NORMALIZE) begin : g_norm
    logic signed [ACC_W-1:0] scaled;
    assign scaled = comb_out >>> GROWTH;
    assign result = scaled[OUT_W-1:0];
  end else begin : g_full
    assign result = comb_out;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      out_valid <= 1'b0;
      out_data  <= '0;
    end else begin
      out_valid <= fire;
      if (fire) out_data <= result;
    end
  end
endmodule

// File: rtl/cic_decim_chk.sv
module cic_decim_chk #(
  parameter int IN_W   = 12,
  parameter int STAGES = 5,
  parameter int RATE   = 8,
  parameter int OUT_W  = 12
) (
  input logic                    clk,
  input logic                    rst,
  input logic                    in_valid,
  input logic signed [IN_W-1:0]  in_data,
  input logic                    out_valid,
  input logic signed [OUT_W-1:0] out_data
);
  localparam int VW = (RATE > 1) ? $clog2(RATE) : 1;
  localparam int SW = $clog2(STAGES + 1);

  logic [VW-1:0] vcnt;
  logic [SW-1:0] scnt;

  always_ff @(posedge clk) begin
    if (rst) begin
      vcnt <= '0;
      scnt <= '0;
    end else begin
      if (in_valid) vcnt <= (vcnt == VW'(RATE - 1)) ? '0 : vcnt + 1'b1;
      if (out_valid && scnt < SW'(STAGES)) scnt <= scnt + 1'b1;
    end
  end

  p_strobe_on_rth_r4: assert property (@(posedge clk) disable iff (rst)
    out_valid |-> ($past(in_valid) && $past(vcnt) == VW'(RATE - 1)));

  if (RATE > 1) begin : g_pulse
    p_single_pulse_r4: assert property (@(posedge clk) disable iff (rst)
      out_valid |=> !out_valid);
  end

  p_hold_r5: assert property (@(posedge clk) disable iff (rst)
    !out_valid |-> $stable(out_data));

  p_zero_head_r7: assert property (@(posedge clk) disable iff (rst)
    (out_valid && scnt < SW'(STAGES)) |-> (out_data == '0));

  p_known_out_r6: assert property (@(posedge clk) disable iff (rst)
    !$isunknown({out_valid, out_data}));
endmodule

bind cic_decim cic_decim_chk #(
  .IN_W(IN_W), .STAGES(STAGES), .RATE(RATE), .OUT_W(OUT_W)
) u_chk (
  .clk(clk), .rst(rst), .in_valid(in_valid), .in_data(in_data),
  .out_valid(out_valid), .out_data(out_data)
);

// File: tb/sim_cic_decim.sv
module sim_cic_decim;
  localparam int IN_W = 12;
  localparam int M    = 5;
  localparam int R0   = 8;
  localparam int D0   = 1;
  localparam int R1V  = 4;
  localparam int D1   = 2;
  localparam int AW   = 27;
  localparam longint GAIN1 = 32768;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic in_valid = 1'b0;
  logic signed [IN_W-1:0] in_data = '0;
  logic v0, v1;
  logic signed [IN_W-1:0] o0;
  logic signed [AW-1:0]   o1;

  int checks = 0;
  int errors = 0;

  always #4 clk = ~clk;

  cic_decim #(.IN_W(IN_W), .STAGES(M), .RATE(R0), .DIFF_DLY(D0), .NORMALIZE(1'b1)) u0 (
    .clk(clk), .rst(rst), .in_valid(in_valid), .in_data(in_data),
    .out_valid(v0), .out_data(o0)
  );

  cic_decim #(.IN_W(IN_W), .STAGES(M), .RATE(R1V), .DIFF_DLY(D1), .NORMALIZE(1'b0)) u1 (
    .clk(clk), .rst(rst), .in_valid(in_valid), .in_data(in_data),
    .out_valid(v1), .out_data(o1)
  );

  task automatic chk(input bit ok, input string req, input longint act, input longint exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual %0d expected %0d", req, act, exp);
    end
  endtask

  // Inputs change at the falling edge; outputs are read at the next falling edge.
  task automatic step(input logic v, input logic signed [IN_W-1:0] d);
    in_valid = v;
    in_data  = d;
    @(posedge clk);
    @(negedge clk);
  endtask

  task automatic do_reset();
    rst = 1'b1;
    step(1'b0, '0);
    step(1'b0, '0);
    rst = 1'b0;
  endtask

  task automatic t_reset();
    rst = 1'b1;
    step(1'b1, 12'sd77);
    step(1'b1, 12'sd77);
    chk(v0 == 1'b0, "R6 u0 valid", longint'(v0), 0);
    chk(o0 == '0,   "R6 u0 data", longint'(o0), 0);
    chk(v1 == 1'b0, "R6 u1 valid", longint'(v1), 0);
    chk(o1 == '0,   "R6 u1 data", longint'(o1), 0);
    rst = 1'b0;
  endtask

  // Constant from reset: zero head (R7), settled value from strobe M*(D+2)+1 (R8).
  task automatic t_dc(input logic signed [IN_W-1:0] c, input string tag);
    int k0 = 0;
    int k1 = 0;
    do_reset();
    for (int i = 0; i < 200; i++) begin
      step(1'b1, c);
      if (v0) begin
        if (k0 < M) chk(o0 == '0, "R7 u0 head", longint'(o0), 0);
        else if (k0 >= M*(D0+2)) chk(o0 == c, {tag, " R2 R8 u0"}, longint'(o0), longint'(c));
        k0++;
      end
      if (v1) begin
        if (k1 < M) chk(o1 == '0, "R7 u1 head", longint'(o1), 0);
        else if (k1 >= M*(D1+2))
          chk(longint'(o1) == longint'(c) * GAIN1, {tag, " R1 R8 u1"},
              longint'(o1), longint'(c) * GAIN1);
        k1++;
      end
    end
    chk(k0 == 200 / R0, "R4 u0 strobe count", k0, 200 / R0);
    chk(k1 == 200 / R1V, "R4 u1 strobe count", k1, 200 / R1V);
  endtask

  // Irregular valid gaps with garbage data while idle (R4, R5).
  task automatic t_gaps();
    int nv = 0;
    logic signed [IN_W-1:0] p0;
    logic signed [AW-1:0]   p1;
    logic signed [IN_W-1:0] last0 = '0;
    logic signed [AW-1:0]   last1 = '0;
    do_reset();
    for (int i = 0; i < 330; i++) begin
      logic v;
      v  = ((i % 5) != 1) && ((i % 7) != 3);
      p0 = o0;
      p1 = o1;
      step(v, v ? 12'sd500 : IN_W'($urandom));
      if (v) nv++;
      chk(v0 == (v && (nv % R0) == 0), "R4 u0 strobe timing", longint'(v0),
          longint'(v && (nv % R0) == 0));
      chk(v1 == (v && (nv % R1V) == 0), "R4 u1 strobe timing", longint'(v1),
          longint'(v && (nv % R1V) == 0));
      if (!v0) chk(o0 == p0, "R5 u0 hold", longint'(o0), longint'(p0));
      if (!v1) chk(o1 == p1, "R5 u1 hold", longint'(o1), longint'(p1));
      if (v0) last0 = o0;
      if (v1) last1 = o1;
    end
    chk(last0 == 12'sd500, "R4 u0 idle data ignored", longint'(last0), 500);
    chk(longint'(last1) == 500 * GAIN1, "R4 u1 idle data ignored", longint'(last1), 500 * GAIN1);
  endtask

  // Reset in mid-stream restarts the decimation count (R9).
  task automatic t_midreset();
    do_reset();
    for (int i = 0; i < 3; i++) step(1'b1, 12'sd9);
    do_reset();
    for (int i = 1; i <= R0; i++) begin
      step(1'b1, 12'sd9);
      chk(v0 == (i == R0), "R9 u0 count restart", longint'(v0), longint'(i == R0));
      chk(v1 == ((i % R1V) == 0), "R9 u1 count restart", longint'(v1), longint'((i % R1V) == 0));
    end
  endtask

  initial begin : watchdog
    repeat (150000) @(posedge clk);
    errors++;
    $display("FAIL watchdog actual timeout expected completion");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    @(negedge clk);
    t_reset();
    t_dc(12'sd100, "R1 R2 positive");
    t_dc(-12'sd1234, "R1 R2 negative");
    t_dc(12'sd2047, "R3 max");
    t_dc(-12'sd2048, "R3 min");
    t_gaps();
    t_midreset();
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule